// File: doc/BRIEF.md
# Run/Set Timekeeping Clock Source

This block produces the slow timekeeping clock that steps a downstream up-counter. In normal operation it divides a 32.768 kHz reference through a binary chain down to a 1 Hz square wave. For setting the time, an operator switches to a manual mode in which every complete press and release of an Advance pushbutton yields exactly one output pulse, so the counter moves on by exactly one.

All three pushbuttons (Run, Set, Advance) are active-low raw contacts that may bounce. Run and Set drive a set/reset style mode latch, so a bounce only repeats the state already held. Advance is synchronized and then debounced by a stability timer counted in reference cycles. A requested change of mode is carried out only in a cycle where both the divided clock and the manual pulse are low. As a result the handover can neither cut a high phase short nor add an edge that the counter would take as a count. The output is a plain level with no handshake: it is a clock, not a data stream, so no back-pressure applies.

Top module: `runset_clk_src`

## Requirements
- R1: While the synchronous active-high `rst` is held, `clk_out` is 0, the mode is Run and the divider is cleared.
- R2: In Run mode `clk_out` is a square wave whose period is 2^DIV_BITS reference cycles and which is high for exactly half of each period (32768 cycles per period by default, i.e. 1 Hz).
- R3: `set_n` low requests Set mode and `run_n` low requests Run mode. The request is held after release. If both are low, Run wins, and repeated bounces on either input change nothing further.
- R4: A mode change takes effect only in a cycle where both the divided clock and the manual pulse are low. A high phase that is in progress when the request arrives finishes at full width, and the first high phase after the change is also full width.
- R5: `adv_n` passes through a two-flop synchronizer and must then stay unchanged for DEB_CYC consecutive reference cycles before the new level is accepted. A low glitch shorter than that produces no pulse.
- R6: In Set mode each debounced press of `adv_n` (1 to 0) followed by its debounced release (0 to 1) gives exactly one `clk_out` high pulse, PULSE_CYC reference cycles wide, which starts after the release.
- R7: `adv_n` has no effect on `clk_out` in Run mode. A press that began in Run mode does not arm a pulse in Set mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 32.768 kHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| run_n | input | 1 | Run pushbutton, active low, raw |
| set_n | input | 1 | Set pushbutton, active low, raw |
| adv_n | input | 1 | Advance pushbutton, active low, raw |
| clk_out | output | 1 | Timekeeping clock to the counter |

## Verification
Two functions can fall on the same cycle: a mode request and a high phase of whichever source is active. The bench presses Set while a divided high phase is showing on the output. It also presses Run while a 4-cycle manual pulse is high. The scoreboard then expects the interrupted phase at its full width, followed by exactly the pulses of the new mode. Any truncated, extra or missing pulse shows up as a width miscompare, as a pulse arriving with an empty queue, or as a missing fall count.

// File: rtl/clksrc_pkg.sv
package clksrc_pkg;
  typedef enum logic {
    MODE_SET = 1'b0,
    MODE_RUN = 1'b1
  } clk_mode_e;
endpackage

// File: rtl/clksrc_sync.sv
module clksrc_sync #(
  parameter int   STAGES  = 2,
  parameter logic IDLE_LV = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= IDLE_LV;
          else     chain_q[g] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= IDLE_LV;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/clksrc_debounce.sv
module clksrc_debounce #(
  parameter int DEB_CYC = 328
) (
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic stable_o
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic [CW-1:0] hold_cnt;
  logic          stable_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt <= '0;
      stable_q <= 1'b1;
    end else if (sync_i != stable_q) begin
      if (hold_cnt == CW'(DEB_CYC - 1)) begin
        stable_q <= sync_i;
        hold_cnt <= '0;
      end else begin
        hold_cnt <= hold_cnt + 1'b1;
      end
    end else begin
      hold_cnt <= '0;
    end
  end

  assign stable_o = stable_q;

  // R5
  accept_follows_input_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(stable_q) |-> (stable_q == $past(sync_i)));
endmodule

// File: rtl/clksrc_divider.sv
module clksrc_divider #(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rst,
  output logic clk1_o
);
  localparam int TW = DIV_BITS - 1;

  logic [TW-1:0] chain_cnt;
  logic          tap_q;
  logic          slow_q;
  logic          tap;

  assign tap = chain_cnt[TW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_cnt <= '0;
      tap_q     <= 1'b0;
      slow_q    <= 1'b0;
    end else begin
      chain_cnt <= chain_cnt + 1'b1;
      tap_q     <= tap;
      if (tap_q && !tap) slow_q <= ~slow_q;
    end
  end

  assign clk1_o = slow_q;

  // R2
  toggle_phase_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(slow_q) |-> (chain_cnt == TW'(1)));
endmodule

// File: rtl/clksrc_mode.sv
module clksrc_mode
  import clksrc_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      run_s_i,
  input  logic      set_s_i,
  input  logic      clk1_i,
  input  logic      pulse_i,
  output clk_mode_e mode_o
);
  logic      want_set_q;
  clk_mode_e mode_q;
  logic      safe;

  assign safe = !clk1_i && !pulse_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      want_set_q <= 1'b0;
      mode_q     <= MODE_RUN;
    end else begin
      if (!run_s_i)      want_set_q <= 1'b0;
      else if (!set_s_i) want_set_q <= 1'b1;
      if (safe) mode_q <= want_set_q ? MODE_SET : MODE_RUN;
    end
  end

  assign mode_o = mode_q;

  // R4
  switch_when_low_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(mode_q) |-> ($past(clk1_i) == 1'b0 && $past(pulse_i) == 1'b0));
endmodule

// File: rtl/clksrc_step.sv
module clksrc_step #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic adv_db_i,
  input  logic set_mode_i,
  output logic pulse_o
);
  localparam int PW = $clog2(PULSE_CYC + 1);

  logic          adv_prev_q;
  logic          armed_q;
  logic [PW-1:0] left_q;
  logic          pressed;
  logic          released;

  assign pressed  = adv_prev_q && !adv_db_i;
  assign released = !adv_prev_q && adv_db_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      adv_prev_q <= 1'b1;
      armed_q    <= 1'b0;
      left_q     <= '0;
    end else begin
      adv_prev_q <= adv_db_i;
      if (!set_mode_i)   armed_q <= 1'b0;
      else if (pressed)  armed_q <= 1'b1;
      else if (released) armed_q <= 1'b0;
      if (set_mode_i && released && armed_q) left_q <= PW'(PULSE_CYC);
      else if (left_q != '0)                 left_q <= left_q - 1'b1;
    end
  end

  assign pulse_o = (left_q != '0);

  // R6
  pulse_in_set_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse_o) |-> $past(set_mode_i));
endmodule

// File: rtl/runset_clk_src.sv
module runset_clk_src
  import clksrc_pkg::*;
#(
  parameter int DIV_BITS    = 15,
  parameter int DEB_CYC     = 328,
  parameter int PULSE_CYC   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_ref,
  input  logic rst,
  input  logic run_n,
  input  logic set_n,
  input  logic adv_n,
  output logic clk_out
);
  logic      run_s, set_s, adv_s, adv_db;
  logic      clk1, pulse, out_q;
  clk_mode_e mode;

  clksrc_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_run (
    .clk(clk_ref), .rst(rst), .din(run_n), .dout(run_s));
  clksrc_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_set (
    .clk(clk_ref), .rst(rst), .din(set_n), .dout(set_s));
  clksrc_sync #(.STAGES(SYNC_STAGES), .IDLE_LV(1'b1)) u_sync_adv (
    .clk(clk_ref), .rst(rst), .din(adv_n), .dout(adv_s));

  clksrc_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
    .clk(clk_ref), .rst(rst), .sync_i(adv_s), .stable_o(adv_db));

  clksrc_divider #(.DIV_BITS(DIV_BITS)) u_div (
    .clk(clk_ref), .rst(rst), .clk1_o(clk1));

  clksrc_step #(.PULSE_CYC(PULSE_CYC)) u_step (
    .clk(clk_ref), .rst(rst), .adv_db_i(adv_db),
    .set_mode_i(mode == MODE_SET), .pulse_o(pulse));

  clksrc_mode u_mode (
    .clk(clk_ref), .rst(rst), .run_s_i(run_s), .set_s_i(set_s),
    .clk1_i(clk1), .pulse_i(pulse), .mode_o(mode));

  always_ff @(posedge clk_ref) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= (mode == MODE_RUN) ? clk1 : pulse;
  end

  assign clk_out = out_q;

  // R1
  reset_state_chk: assert property (@(posedge clk_ref)
    rst |=> (!clk_out && mode == MODE_RUN));
endmodule

// File: tb/runset_clk_src_bench.sv
`timescale 1ns/1ps
module runset_clk_src_bench;
  localparam int DIVB = 6;
  localparam int HALF = 1 << (DIVB - 1);
  localparam int PER  = 1 << DIVB;
  localparam int PW   = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] btn = 3'b111;   // [0]=run, [1]=set, [2]=advance
  logic       clk_out;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, nrise = 0, nfall = 0, rise_cyc = 0;
  logic prev = 1'b0;
  bit done = 1'b0;
  int    q_w[$];
  string q_tag[$];

  always #5 clk = ~clk;

  runset_clk_src #(.DIV_BITS(DIVB), .DEB_CYC(20), .PULSE_CYC(PW), .SYNC_STAGES(2))
    u_runset_clk_src (.clk_ref(clk), .rst(rst), .run_n(btn[0]), .set_n(btn[1]),
                      .adv_n(btn[2]), .clk_out(clk_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic push(input int w, input string tag);
    q_w.push_back(w);
    q_tag.push_back(tag);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  // monitor: pops one expected width per completed high pulse
  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(1'b0, "watchdog", cyc, 150000);
      finish_run();
    end
    if (!rst) begin
      if (clk_out && !prev) begin
        nrise++;
        rise_cyc = cyc;
      end
      if (!clk_out && prev) begin
        nfall++;
        if (q_w.size() == 0) begin
          if (!done) chk(1'b0, "R4 unexpected pulse", cyc - rise_cyc, 0);
        end else begin
          int w;
          string t;
          w = q_w.pop_front();
          t = q_tag.pop_front();
          chk((cyc - rise_cyc) == w, t, cyc - rise_cyc, w);
        end
      end
    end
    prev = clk_out;
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bounce(input int idx, input logic lvl);
    for (int k = 0; k < 3; k++) begin
      btn[idx] = lvl;
      cycles(2);
      btn[idx] = ~lvl;
      cycles(1);
    end
    btn[idx] = lvl;
  endtask

  task automatic adv_cycle();
    bounce(2, 1'b0);
    cycles(40);
    bounce(2, 1'b1);
    cycles(40);
  endtask

  task automatic wait_rises(input int target, input int limit);
    for (int k = 0; k < limit && nrise < target; k++) cycles(1);
  endtask

  task automatic wait_falls(input int target, input int limit);
    for (int k = 0; k < limit && nfall < target; k++) cycles(1);
  endtask

  initial begin
    int t0;
    cycles(5);
    chk(clk_out == 1'b0, "R1 reset output", clk_out, 0);
    rst = 1'b0;
    cycles(3);
    chk(clk_out == 1'b0, "R1 divider cleared", clk_out, 0);

    // Run mode: six full-width high phases expected
    for (int i = 0; i < 6; i++) push(HALF, "R2 run width");
    wait_rises(1, 400);
    t0 = rise_cyc;
    wait_rises(2, 400);
    chk(rise_cyc - t0 == PER, "R2 period", rise_cyc - t0, PER);
    // R7: advance activity in Run mode must not add pulses
    adv_cycle();
    wait_rises(6, 800);
    // R4: Set requested while the divided clock is high
    bounce(1, 1'b0);
    cycles(10);
    bounce(1, 1'b1);
    cycles(4 * PER);
    chk(nfall == 6, "R4 handover to set", nfall, 6);
    chk(q_w.size() == 0, "R7 no advance pulse in run", q_w.size(), 0);

    // Set mode: one pulse per bounced press/release
    for (int i = 0; i < 3; i++) begin
      push(PW, "R6 manual width");
      adv_cycle();
      chk(nfall == 7 + i, "R6 one pulse per press", nfall, 7 + i);
    end
    // R5: short glitch rejected
    btn[2] = 1'b0;
    cycles(8);
    btn[2] = 1'b1;
    cycles(60);
    chk(nfall == 9, "R5 glitch ignored", nfall, 9);

    // R4: Run pressed while the manual pulse is high
    push(PW, "R4 pulse kept full");
    bounce(2, 1'b0);
    cycles(40);
    bounce(2, 1'b1);
    wait_rises(10, 200);
    btn[0] = 1'b0;
    push(HALF, "R4 first run width");
    push(HALF, "R4 second run width");
    cycles(10);
    btn[0] = 1'b1;
    wait_falls(12, 4 * PER);
    chk(nfall == 12, "R4 run resumes", nfall, 12);

    // R3: both buttons low, Run wins
    for (int i = 0; i < 3; i++) push(HALF, "R3 run kept");
    btn[0] = 1'b0;
    btn[1] = 1'b0;
    wait_falls(15, 5 * PER);
    chk(nfall == 15, "R3 run priority", nfall, 15);
    done = 1'b1;
    btn[1] = 1'b1;
    cycles(5);
    btn[0] = 1'b1;
    chk(q_w.size() == 0, "R2 scoreboard drained", q_w.size(), 0);
    finish_run();
  end
endmodule